// File: doc/BRIEF.md
# Device Control Register File

This block is the host-facing control register bank of a paravirtual RDMA-style network adapter. The host reads and writes 32-bit little-endian words over a simple request/response register bus. The bank holds these registers:

- a read-only hardware version word;
- an error/status word;
- a control word;
- a command request word;
- two halves of a 64-bit shared-region base address;
- an interrupt mask.

Some writes do more than store a value. Each of these side effects becomes a single-cycle pulse toward the device core:

- The upper address half starts a shared-region load, followed by a capability fill.
- A control write can decode to activate, unquiesce or reset.
- A request write of zero starts command execution.

The device core owns everything behind those pulses, including any memory fetch and the commands themselves. It consumes the assembled address and the interrupt mask as level outputs.

Top module: `devctl_regbank`

## Requirements
- R1: After reset the version word reads the parameter HW_VERSION (default 0x0001_0002) and the error word reads 0x0000_FFFF. The address output, interrupt mask, control word and request word are 0, and no pulse is high.
- R2: Each request produces exactly one response, in the cycle after the request is sampled. A request is rejected (response error bit = 1, read data 0, no register change, no pulse) under any of these conditions:
  - its byte enable is not 4'hF;
  - its offset is not a multiple of 4;
  - its word index is 7 or above.
- R3: A write to the address-low word (offset 0x10) sets the 64-bit address output to {32'h0, data}.
- R4: A write to the address-high word (offset 0x14) ORs the data into address bits 63:32. It raises the load pulse in the response cycle and the capability pulse in the cycle after that.
- R5: A write to the control word (offset 0x08) stores the value. Code 1 raises the activate pulse, code 2 the unquiesce pulse, and code 3 the reset pulse. Any other code raises no pulse.
- R6: An activate command clears the error word to 0.
- R7: A write to the interrupt mask (offset 0x18) stores the value and drives it on the mask output.
- R8: A write to the request word (offset 0x0C) stores the value. The execute pulse is raised only when the value is 0.
- R9: At most one of the load, activate, unquiesce, reset and execute pulses is high in any cycle.
- R10: A write to the version word (offset 0x00) is accepted without error but leaves its value unchanged.
- R11: A write to the error word (offset 0x04) stores the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| req_valid | input | 1 | request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | byte offset into the bank |
| req_be | input | 4 | byte enables, must be all ones |
| req_wdata | input | 32 | write data |
| rsp_valid | output | 1 | response strobe |
| rsp_err | output | 1 | access rejected |
| rsp_rdata | output | 32 | read data |
| shared_addr | output | 64 | assembled shared-region base address |
| irq_mask | output | 32 | current interrupt mask |
| load_pulse | output | 1 | start shared-region load |
| caps_pulse | output | 1 | fill capabilities, one cycle after load |
| activate_pulse | output | 1 | activate device |
| unquiesce_pulse | output | 1 | unquiesce device |
| reset_pulse | output | 1 | device-level reset command |
| exec_pulse | output | 1 | execute the posted command |

## Verification
The capability pulse trails the load pulse by one cycle. It can therefore coincide with a pulse caused by the next write. The bench provokes this by issuing an address-high write and then a control write with code 1 on the very next cycle. It then checks that the capability pulse and the activate pulse are both high in that second response cycle. It also checks that the error word then reads 0.

// File: rtl/devctl_pkg.sv
package devctl_pkg;

  typedef enum logic [2:0] {
    SEL_VER = 3'd0,
    SEL_ERR = 3'd1,
    SEL_CTL = 3'd2,
    SEL_REQ = 3'd3,
    SEL_ALO = 3'd4,
    SEL_AHI = 3'd5,
    SEL_MSK = 3'd6
  } reg_sel_e;

  localparam int NUM_REGS  = 7;
  localparam int NUM_PULSE = 5;

  localparam int P_LOAD = 0;
  localparam int P_ACT  = 1;
  localparam int P_UNQ  = 2;
  localparam int P_RST  = 3;
  localparam int P_EXEC = 4;

  localparam logic [31:0] ERR_RESET = 32'h0000_FFFF;

endpackage

// File: rtl/devctl_decode.sv
module devctl_decode
  import devctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  output logic              hit,
  output reg_sel_e          sel
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             full_word;

  assign idx       = addr[ADDR_W-1:2];
  assign aligned   = (addr[1:0] == 2'b00);
  assign full_word = (be == 4'hF);
  assign hit       = aligned && full_word && (idx <= LAST_IDX);
  assign sel       = reg_sel_e'(idx[2:0]);

endmodule

// File: rtl/devctl_cmd_decode.sv
module devctl_cmd_decode
  import devctl_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ACT_CODE = 32'd1,
  parameter logic [31:0] UNQ_CODE = 32'd2,
  parameter logic [31:0] RST_CODE = 32'd3
) (
  input  logic                 wr_ctl,
  input  logic                 wr_req,
  input  logic                 wr_ahi,
  input  logic [DATA_W-1:0]    wdata,
  output logic [NUM_PULSE-1:0] nxt
);
  always_comb begin
    nxt = '0;
    if (wr_ahi) begin
      nxt[P_LOAD] = 1'b1;
    end
    if (wr_req && (wdata == '0)) begin
      nxt[P_EXEC] = 1'b1;
    end
    if (wr_ctl) begin
      if (wdata == DATA_W'(ACT_CODE)) nxt[P_ACT] = 1'b1;
      if (wdata == DATA_W'(UNQ_CODE)) nxt[P_UNQ] = 1'b1;
      if (wdata == DATA_W'(RST_CODE)) nxt[P_RST] = 1'b1;
    end
  end

endmodule

// File: rtl/devctl_pulse.sv
module devctl_pulse
  import devctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PULSE-1:0] nxt,
  output logic [NUM_PULSE-1:0] q,
  output logic                 caps
);
  for (genvar i = 0; i < NUM_PULSE; i++) begin : g_pulse
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) caps <= 1'b0;
    else     caps <= q[P_LOAD];
  end

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(q)); // R9

  AST_CAPS_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (rst)
    q[P_LOAD] |=> caps); // R4

endmodule

// File: rtl/devctl_regbank.sv
module devctl_regbank
  import devctl_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter logic [31:0] HW_VERSION = 32'h0001_0002,
  parameter logic [31:0] ACT_CODE   = 32'd1,
  parameter logic [31:0] UNQ_CODE   = 32'd2,
  parameter logic [31:0] RST_CODE   = 32'd3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic [63:0]       shared_addr,
  output logic [31:0]       irq_mask,
  output logic              load_pulse,
  output logic              caps_pulse,
  output logic              activate_pulse,
  output logic              unquiesce_pulse,
  output logic              reset_pulse,
  output logic              exec_pulse
);
  localparam int DATA_W = 32;

  logic             hit;
  reg_sel_e         sel;
  logic             wr_ok;
  logic [DATA_W-1:0] err_q, ctl_q, req_q, msk_q;
  logic [63:0]      addr_q;
  logic [NUM_PULSE-1:0] pulse_nxt, pulse_q;
  logic [DATA_W-1:0] rd_mux;

  devctl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (req_addr),
    .be   (req_be),
    .hit  (hit),
    .sel  (sel)
  );

  assign wr_ok = req_valid && req_write && hit;

  devctl_cmd_decode #(
    .DATA_W   (DATA_W),
    .ACT_CODE (ACT_CODE),
    .UNQ_CODE (UNQ_CODE),
    .RST_CODE (RST_CODE)
  ) u_cmd (
    .wr_ctl (wr_ok && (sel == SEL_CTL)),
    .wr_req (wr_ok && (sel == SEL_REQ)),
    .wr_ahi (wr_ok && (sel == SEL_AHI)),
    .wdata  (req_wdata),
    .nxt    (pulse_nxt)
  );

  devctl_pulse u_pulse (
    .clk  (clk),
    .rst  (rst),
    .nxt  (pulse_nxt),
    .q    (pulse_q),
    .caps (caps_pulse)
  );

  // register storage
  always_ff @(posedge clk) begin
    if (rst) begin
      err_q  <= ERR_RESET;
      ctl_q  <= '0;
      req_q  <= '0;
      msk_q  <= '0;
      addr_q <= '0;
    end else if (wr_ok) begin
      unique case (sel)
        SEL_ERR: err_q <= req_wdata;
        SEL_CTL: begin
          ctl_q <= req_wdata;
          if (req_wdata == ACT_CODE) err_q <= '0;
        end
        SEL_REQ: req_q <= req_wdata;
        SEL_ALO: addr_q <= {32'h0, req_wdata};
        SEL_AHI: addr_q[63:32] <= addr_q[63:32] | req_wdata;
        SEL_MSK: msk_q <= req_wdata;
        default: ;
      endcase
    end
  end

  // read path
  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_VER: rd_mux = HW_VERSION;
      SEL_ERR: rd_mux = err_q;
      SEL_CTL: rd_mux = ctl_q;
      SEL_REQ: rd_mux = req_q;
      SEL_ALO: rd_mux = addr_q[31:0];
      SEL_AHI: rd_mux = addr_q[63:32];
      SEL_MSK: rd_mux = msk_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !hit;
      rsp_rdata <= (req_valid && !req_write && hit) ? rd_mux : '0;
    end
  end

  assign shared_addr     = addr_q;
  assign irq_mask        = msk_q;
  assign load_pulse      = pulse_q[P_LOAD];
  assign activate_pulse  = pulse_q[P_ACT];
  assign unquiesce_pulse = pulse_q[P_UNQ];
  assign reset_pulse     = pulse_q[P_RST];
  assign exec_pulse      = pulse_q[P_EXEC];

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (pulse_q == '0)); // R2

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid)); // R2

  AST_ACT_CLEARS_ERR: assert property (@(posedge clk) disable iff (rst)
    activate_pulse |-> (err_q == '0)); // R6

  AST_EXEC_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    exec_pulse |-> (req_q == '0)); // R8

  AST_LOAD_SETS_HIGH: assert property (@(posedge clk) disable iff (rst)
    load_pulse |-> (rsp_valid && !rsp_err)); // R4

endmodule

// File: tb/devctl_regbank_bench.sv
module devctl_regbank_bench;
  localparam int          ADDR_W = 8;
  localparam logic [31:0] HW_VER = 32'h0001_0002;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0]  req_be = 4'hF;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [63:0] shared_addr;
  logic [31:0] irq_mask;
  logic load_pulse, caps_pulse, activate_pulse, unquiesce_pulse, reset_pulse, exec_pulse;

  int checks = 0;
  int failures = 0;

  // captured results
  logic        c_valid, c_err, c_caps1, c_caps2;
  logic [31:0] c_data;
  logic [4:0]  c_p1, c_p2; // {exec,rst,unq,act,load}

  always #2 clk = ~clk;

  devctl_regbank #(.ADDR_W(ADDR_W), .HW_VERSION(HW_VER)) u_devctl_regbank (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .shared_addr(shared_addr), .irq_mask(irq_mask),
    .load_pulse(load_pulse), .caps_pulse(caps_pulse),
    .activate_pulse(activate_pulse), .unquiesce_pulse(unquiesce_pulse),
    .reset_pulse(reset_pulse), .exec_pulse(exec_pulse)
  );

  function automatic logic [4:0] pulses();
    return {exec_pulse, reset_pulse, unquiesce_pulse, activate_pulse, load_pulse};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [ADDR_W-1:0] a,
                     input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    c_valid = rsp_valid; c_err = rsp_err; c_data = rsp_rdata;
    c_p1 = pulses(); c_caps1 = caps_pulse;
    @(negedge clk);
    c_p2 = pulses(); c_caps2 = caps_pulse;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
    bus(1'b0, a, 4'hF, 32'h0);
    v = c_data;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic [31:0] hi_exp;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 pulses", {59'b0, pulses()}, 64'h0);
    chk("R1 addr", shared_addr, 64'h0);
    chk("R1 mask", {32'h0, irq_mask}, 64'h0);
    rd(8'h00, v); chk("R1 version", {32'h0, v}, {32'h0, HW_VER});
    rd(8'h04, v); chk("R1 error", {32'h0, v}, 64'h0000_FFFF);
    rd(8'h08, v); chk("R1 control", {32'h0, v}, 64'h0);
    rd(8'h0C, v); chk("R1 request", {32'h0, v}, 64'h0);

    // R10 version read-only
    bus(1'b1, 8'h00, 4'hF, 32'hDEAD_BEEF);
    chk("R10 no error", {63'h0, c_err}, 64'h0);
    rd(8'h00, v); chk("R10 unchanged", {32'h0, v}, {32'h0, HW_VER});

    // R11 error writable
    bus(1'b1, 8'h04, 4'hF, 32'h0000_1234);
    rd(8'h04, v); chk("R11 error store", {32'h0, v}, 64'h1234);

    // R3 low address
    bus(1'b1, 8'h10, 4'hF, 32'hAABB_CCDD);
    chk("R3 addr", shared_addr, 64'h0000_0000_AABB_CCDD);
    chk("R3 no pulse", {59'b0, c_p1}, 64'h0);

    // R4 high address OR and pulse order
    bus(1'b1, 8'h14, 4'hF, 32'h0000_0011);
    chk("R4 load now", {59'b0, c_p1}, 64'h1);
    chk("R4 caps not yet", {63'b0, c_caps1}, 64'h0);
    chk("R4 caps next", {63'b0, c_caps2}, 64'h1);
    chk("R4 load gone", {59'b0, c_p2}, 64'h0);
    bus(1'b1, 8'h14, 4'hF, 32'h0000_0022);
    chk("R4 or bits", shared_addr, 64'h0000_0033_AABB_CCDD);
    rd(8'h14, v); chk("R4 readback", {32'h0, v}, 64'h33);
    bus(1'b1, 8'h10, 4'hF, 32'h0000_0001);
    chk("R3 low replaces", shared_addr, 64'h1);

    // R5/R6 control sweep
    for (int c = 0; c < 8; c++) begin
      bus(1'b1, 8'h04, 4'hF, 32'h0000_FFFF);
      bus(1'b1, 8'h08, 4'hF, 32'(c));
      chk($sformatf("R5 code %0d act", c), {63'b0, c_p1[1]}, {63'b0, c == 1});
      chk($sformatf("R5 code %0d unq", c), {63'b0, c_p1[2]}, {63'b0, c == 2});
      chk($sformatf("R5 code %0d rst", c), {63'b0, c_p1[3]}, {63'b0, c == 3});
      chk($sformatf("R9 code %0d others", c), {62'b0, c_p1[4], c_p1[0]}, 64'h0);
      rd(8'h08, v); chk($sformatf("R5 stored %0d", c), {32'h0, v}, 64'(c));
      rd(8'h04, v); chk($sformatf("R6 err after %0d", c), {32'h0, v},
                        (c == 1) ? 64'h0 : 64'hFFFF);
    end

    // R8 request sweep
    for (int i = 0; i < 6; i++) begin
      logic [31:0] d;
      d = (i == 5) ? 32'h8000_0000 : 32'(i * 3);
      bus(1'b1, 8'h0C, 4'hF, d);
      chk($sformatf("R8 exec d=%h", d), {59'b0, c_p1}, (d == 0) ? 64'h10 : 64'h0);
      rd(8'h0C, v); chk("R8 stored", {32'h0, v}, {32'h0, d});
    end

    // R7 mask patterns
    for (int i = 0; i < 4; i++) begin
      logic [31:0] d;
      d = 32'hFFFF_FFFF >> (i * 8);
      bus(1'b1, 8'h18, 4'hF, d);
      chk("R7 mask out", {32'h0, irq_mask}, {32'h0, d});
      rd(8'h18, v); chk("R7 mask read", {32'h0, v}, {32'h0, d});
    end

    // R2 offset sweep: reads everywhere, writes only where rejected
    for (int a = 0; a < 64; a++) begin
      logic ok;
      ok = ((a % 4) == 0) && ((a / 4) < 7);
      bus(1'b0, 8'(a), 4'hF, 32'h0);
      chk($sformatf("R2 rd err a=%0d", a), {62'b0, c_valid, c_err}, {62'b0, 1'b1, !ok});
      if (!ok) begin
        chk($sformatf("R2 rd data a=%0d", a), {32'h0, c_data}, 64'h0);
        bus(1'b1, 8'(a), 4'hF, 32'h0);
        chk($sformatf("R2 wr err a=%0d", a), {63'b0, c_err}, 64'h1);
        chk($sformatf("R2 wr quiet a=%0d", a), {58'b0, c_caps2, c_p1}, 64'h0);
      end
    end
    chk("R2 mask kept", {32'h0, irq_mask}, 64'hFF);
    chk("R2 addr kept", shared_addr, 64'h0000_0033_0000_0001 & 64'h0000_0000_0000_0001);

    // R2 byte-enable sweep on request word with value 0 (would execute)
    for (int b = 0; b < 15; b++) begin
      bus(1'b1, 8'h0C, 4'(b), 32'h0);
      chk($sformatf("R2 be=%0h err", b), {63'b0, c_err}, 64'h1);
      chk($sformatf("R2 be=%0h quiet", b), {59'b0, c_p1}, 64'h0);
    end
    rd(8'h0C, v); chk("R2 request kept", {32'h0, v}, 64'h8000_0000);

    // Concurrency: capability pulse meets activate pulse
    bus(1'b1, 8'h04, 4'hF, 32'h0000_ABCD);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h14; req_be = 4'hF; req_wdata = 32'h1;
    @(negedge clk);
    req_addr = 8'h08; req_wdata = 32'h1;
    hi_exp = 32'h1;
    chk("R4 overlap load", {63'b0, load_pulse}, 64'h1);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk("R4 overlap caps", {63'b0, caps_pulse}, 64'h1);
    chk("R5 overlap act", {63'b0, activate_pulse}, 64'h1);
    chk("R9 overlap load off", {63'b0, load_pulse}, 64'h0);
    chk("R4 overlap addr", {32'h0, shared_addr[63:32]}, {32'h0, hi_exp});
    rd(8'h04, v); chk("R6 overlap err", {32'h0, v}, 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule